// File: doc/BRIEF.md
# DDR2 Read Burst Timing Generator

This block models the read side of a DDR2-style memory device at clock-cycle resolution. On every rising clock edge it samples the four active-low command pins. When they encode a READ, it captures the column address, the burst-length select and the two latency settings. A fixed number of cycles later it returns a burst from a small internal two-bank store, together with a strobe that carries a one-cycle preamble and a one-cycle postamble. A latency setting outside the supported range is clamped to the nearest supported value.

Each clock cycle carries two data beats on two lanes. The rise lane holds the beat launched on the strobe's rising edge and the fall lane holds the beat on its falling edge. Strobe activity is reported as an output-enable plus a level flag. When the flag is set, the strobe is high for the first half of the cycle and low for the second. When the enable is set and the flag is clear, the strobe is held low for the whole cycle. A separate write port fills the store so that bursts return known contents.

Top module: `ddr2_rd_burst_gen`

## Requirements
- R1: While `rst` is high, the next clock edge clears `dq_oe`, `strb_oe`, `strb_lvl`, `dq_rise` and `dq_fall`, and they stay clear until a READ is issued.
- R2: A READ is decoded on a clock edge where `cs_n`=0, `ras_n`=1, `cas_n`=0 and `we_n`=1. Every other pattern is ignored: it starts no burst and leaves bursts already in flight unchanged.
- R3: A READ is captured at edge E. Its first beat pair is present in the cycle that follows edge E+RL, where RL = CL + AL is taken from `cas_lat` and `add_lat` as sampled at E.
- R4: If `bl8`=1 when the READ is captured, the burst is 8 beats over 4 cycles; if `bl8`=0, it is 4 beats over 2 cycles. Beat 2k is on `dq_rise` and beat 2k+1 is on `dq_fall` in the k-th data cycle.
- R5: In the cycle just before the first data cycle of a burst, `strb_oe`=1 and `strb_lvl`=0. This preamble is the low strobe that precedes data.
- R6: In every cycle with `dq_oe`=1, `strb_oe`=1 and `strb_lvl`=1, so each beat lines up with one strobe edge. `strb_lvl` is never 1 while `strb_oe`=0.
- R7: With burst length BL and start column C, beat i reads column (C with its low log2(BL) bits cleared) OR ((C+i) mod BL). The sequence wraps inside the aligned block.
- R8: In the cycle after the last data cycle, `strb_oe`=1, `strb_lvl`=0 and `dq_oe`=0. This is the postamble. In the cycle after it, `strb_oe`=0 unless another burst's preamble or data falls there. Idle cycles drive 0 on both data lanes.
- R9: READs with equal latency issued exactly BL/2 cycles apart return data with no idle cycle between bursts. `strb_oe` stays 1 throughout, and no preamble is inserted between the bursts.
- R10: A write with `wr_en`=1 on a clock edge stores `wr_data` at column `wr_addr`. A READ issued after that edge returns the new value.
- R11: CAS-latency values below 3 are treated as 3 and values above 6 are treated as 6. Additive-latency values above 4 are treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| we_n | input | 1 | Write-enable pin, active low |
| col_addr | input | COL_W | Start column sampled with a READ |
| cas_lat | input | LAT_W | CAS latency in cycles, sampled with a READ |
| add_lat | input | LAT_W | Additive latency in cycles, sampled with a READ |
| bl8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | COL_W | Store write column |
| wr_data | input | DATA_W | Store write data |
| dq_rise | output | DATA_W | Beat launched on the strobe's rising edge |
| dq_fall | output | DATA_W | Beat launched on the strobe's falling edge |
| dq_oe | output | 1 | Data output-enable |
| strb_lvl | output | 1 | 1: strobe high then low within the cycle; 0: strobe low |
| strb_oe | output | 1 | Strobe output-enable |

## Verification
A READ whose command pins are driven before edge E has its preamble in the cycle after edge E+RL-1. Its beat pairs follow in the cycles after edges E+RL through E+RL+BL/2-1, and its postamble comes one cycle after that. The reference model in the bench is written to that timing. When it issues a READ, it computes the target cycle numbers from its own clamped latency and its own copy of the store, then marks those cycles in per-cycle expectation arrays. On the falling edge of every clock, the outputs are compared against the entry for the current cycle. The strobe enable is derived from data activity in the previous, current and next cycles. This way the preamble, the postamble and gapless streaming are all checked against the same latency arithmetic.

// File: rtl/ddr2rb_pkg.sv
package ddr2rb_pkg;

  // Command classes the read path distinguishes.
  typedef enum logic [0:0] {
    CMD_NOP  = 1'b0,
    CMD_READ = 1'b1
  } cmd_e;

  // Lane index of the even / odd column bank.
  localparam int unsigned BANK_EV = 0;
  localparam int unsigned BANK_OD = 1;

  // Cycles between the capture edge and the first data cycle that the
  // internal pipe itself consumes (delay line head, sequencer, store, output).
  localparam int unsigned PIPE_LAT = 3;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    return (!cs_n && ras_n && !cas_n && we_n) ? CMD_READ : CMD_NOP;
  endfunction

endpackage

// File: rtl/ddr2rb_lat_line.sv
// Variable-delay line: a request is written at a stage chosen by its latency
// and moves one stage toward the head per clock.
module ddr2rb_lat_line #(
  parameter int unsigned COL_W = 6,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_vld,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic             ins_bl8,
  input  logic [COL_W-1:0] ins_col,
  output logic             head_vld,
  output logic             head_bl8,
  output logic [COL_W-1:0] head_col
);

  logic             st_vld [DEPTH];
  logic             st_bl8 [DEPTH];
  logic [COL_W-1:0] st_col [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic hit;
    assign hit = ins_vld && (ins_idx == IDX_W'(s));

    if (s == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          st_vld[s] <= 1'b0;
          st_bl8[s] <= 1'b0;
          st_col[s] <= '0;
        end else if (hit) begin
          st_vld[s] <= 1'b1;
          st_bl8[s] <= ins_bl8;
          st_col[s] <= ins_col;
        end else begin
          st_vld[s] <= 1'b0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          st_vld[s] <= 1'b0;
          st_bl8[s] <= 1'b0;
          st_col[s] <= '0;
        end else if (hit) begin
          st_vld[s] <= 1'b1;
          st_bl8[s] <= ins_bl8;
          st_col[s] <= ins_col;
        end else begin
          st_vld[s] <= st_vld[s+1];
          st_bl8[s] <= st_bl8[s+1];
          st_col[s] <= st_col[s+1];
        end
      end
    end
  end

  assign head_vld = st_vld[0];
  assign head_bl8 = st_bl8[0];
  assign head_col = st_col[0];

endmodule

// File: rtl/ddr2rb_burst_seq.sv
// Burst sequencer: walks the wrapped column order two beats per cycle and
// splits each pair onto the even and odd banks.
module ddr2rb_burst_seq #(
  parameter int unsigned COL_W = 6,
  localparam int unsigned BANK_W = COL_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_vld,
  input  logic              ld_bl8,
  input  logic [COL_W-1:0]  ld_col,
  output logic              act,
  output logic [BANK_W-1:0] ev_addr,
  output logic [BANK_W-1:0] od_addr,
  output logic              swap
);

  logic             bl8_q;
  logic [COL_W-1:0] base_q;
  logic [2:0]       off_q;
  logic [1:0]       left_q;
  logic [2:0]       mask;
  logic [2:0]       ld_mask;
  logic [2:0]       off_nx;
  logic [COL_W-1:0] col_a;
  logic [COL_W-1:0] col_b;

  assign mask    = bl8_q  ? 3'b111 : 3'b011;
  assign ld_mask = ld_bl8 ? 3'b111 : 3'b011;
  assign off_nx  = (off_q + 3'd1) & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      bl8_q  <= 1'b0;
      base_q <= '0;
      off_q  <= '0;
      left_q <= '0;
    end else if (ld_vld) begin
      act    <= 1'b1;
      bl8_q  <= ld_bl8;
      base_q <= ld_col;
      off_q  <= ld_col[2:0] & ld_mask;
      left_q <= ld_bl8 ? 2'd3 : 2'd1;
    end else if (act) begin
      if (left_q == 2'd0) act <= 1'b0;
      else                left_q <= left_q - 2'd1;
      off_q <= (off_q + 3'd2) & mask;
    end
  end

  assign col_a = {base_q[COL_W-1:3], (base_q[2:0] & ~mask) | off_q};
  assign col_b = {base_q[COL_W-1:3], (base_q[2:0] & ~mask) | off_nx};

  // The pair always holds one even and one odd column.
  assign swap    = off_q[0];
  assign ev_addr = swap ? col_b[COL_W-1:1] : col_a[COL_W-1:1];
  assign od_addr = swap ? col_a[COL_W-1:1] : col_b[COL_W-1:1];

endmodule

// File: rtl/ddr2rb_store.sv
// Two column banks (even, odd), each one write port and one registered read.
module ddr2rb_store #(
  parameter int unsigned COL_W  = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BANK_W = COL_W - 1,
  localparam int unsigned BANK_D = 1 << BANK_W
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [COL_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [1:0][BANK_W-1:0] rd_addr,
  output logic [1:0][DATA_W-1:0] rd_q
);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [BANK_D];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr[0] == 1'(b))) mem[wr_addr[COL_W-1:1]] <= wr_data;
      rd_q[b] <= mem[rd_addr[b]];
    end
  end

endmodule

// File: rtl/ddr2_rd_burst_gen.sv
module ddr2_rd_burst_gen #(
  parameter int unsigned COL_W  = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LAT_W  = 3,
  parameter int unsigned CL_MIN = 3,
  parameter int unsigned CL_MAX = 6,
  parameter int unsigned AL_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [LAT_W-1:0]  cas_lat,
  input  logic [LAT_W-1:0]  add_lat,
  input  logic              bl8,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dq_rise,
  output logic [DATA_W-1:0] dq_fall,
  output logic              dq_oe,
  output logic              strb_lvl,
  output logic              strb_oe
);
  import ddr2rb_pkg::*;

  localparam int unsigned RL_MAX = CL_MAX + AL_MAX;
  localparam int unsigned LINE_D = RL_MAX - PIPE_LAT + 1;
  localparam int unsigned IDX_W  = (LINE_D > 1) ? $clog2(LINE_D) : 1;
  localparam int unsigned BANK_W = COL_W - 1;
  localparam int unsigned SUM_W  = LAT_W + 2;

  // Command decode and latency clamp.
  cmd_e             cmd;
  logic [LAT_W-1:0] cl_c;
  logic [LAT_W-1:0] al_c;
  logic [SUM_W-1:0] rl_sum;
  logic [IDX_W-1:0] ins_idx;

  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

  always_comb begin
    if (cas_lat < LAT_W'(CL_MIN))      cl_c = LAT_W'(CL_MIN);
    else if (cas_lat > LAT_W'(CL_MAX)) cl_c = LAT_W'(CL_MAX);
    else                               cl_c = cas_lat;
    if (add_lat > LAT_W'(AL_MAX))      al_c = LAT_W'(AL_MAX);
    else                               al_c = add_lat;
    rl_sum  = SUM_W'(cl_c) + SUM_W'(al_c);
    ins_idx = IDX_W'(rl_sum - SUM_W'(PIPE_LAT));
  end

  // Latency delay line.
  logic             head_vld;
  logic             head_bl8;
  logic [COL_W-1:0] head_col;

  ddr2rb_lat_line #(
    .COL_W (COL_W),
    .DEPTH (LINE_D)
  ) u_line (
    .clk      (clk),
    .rst      (rst),
    .ins_vld  (cmd == CMD_READ),
    .ins_idx  (ins_idx),
    .ins_bl8  (bl8),
    .ins_col  (col_addr),
    .head_vld (head_vld),
    .head_bl8 (head_bl8),
    .head_col (head_col)
  );

  // Burst address sequencer.
  logic              seq_act;
  logic              seq_swap;
  logic [BANK_W-1:0] seq_ev;
  logic [BANK_W-1:0] seq_od;

  ddr2rb_burst_seq #(
    .COL_W (COL_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .ld_vld  (head_vld),
    .ld_bl8  (head_bl8),
    .ld_col  (head_col),
    .act     (seq_act),
    .ev_addr (seq_ev),
    .od_addr (seq_od),
    .swap    (seq_swap)
  );

  // Column store.
  logic [1:0][BANK_W-1:0] rd_addr;
  logic [1:0][DATA_W-1:0] rd_q;

  always_comb begin
    rd_addr[BANK_EV] = seq_ev;
    rd_addr[BANK_OD] = seq_od;
  end

  ddr2rb_store #(
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_q    (rd_q)
  );

  // Read-data stage alignment and registered outputs.
  logic rd_act;
  logic rd_swap;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act  <= 1'b0;
      rd_swap <= 1'b0;
    end else begin
      rd_act  <= seq_act;
      rd_swap <= seq_swap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_rise  <= '0;
      dq_fall  <= '0;
      dq_oe    <= 1'b0;
      strb_lvl <= 1'b0;
      strb_oe  <= 1'b0;
    end else begin
      dq_oe    <= rd_act;
      strb_lvl <= rd_act;
      // next-cycle data (preamble), data, or previous-cycle data (postamble)
      strb_oe  <= seq_act | rd_act | dq_oe;
      if (rd_act) begin
        dq_rise <= rd_swap ? rd_q[BANK_OD] : rd_q[BANK_EV];
        dq_fall <= rd_swap ? rd_q[BANK_EV] : rd_q[BANK_OD];
      end else begin
        dq_rise <= '0;
        dq_fall <= '0;
      end
    end
  end

endmodule

// File: rtl/ddr2rb_chk.sv
module ddr2rb_chk (
  input logic clk,
  input logic rst,
  input logic dq_oe,
  input logic strb_lvl,
  input logic strb_oe
);

  // R1: reset clears both enables on the next edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!dq_oe && !strb_oe));

  // R5: data never starts without a low strobe cycle just before it
  p_preamble_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> ($past(strb_oe) && !$past(strb_lvl)));

  // R6: each data cycle carries a toggling strobe
  p_strobe_in_data_r6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (strb_oe && strb_lvl));

  // R6: strobe level flag only while the strobe is driven
  p_lvl_needs_oe_r6: assert property (@(posedge clk) disable iff (rst)
    strb_lvl |-> strb_oe);

  // R8: the cycle after data ends is a driven low strobe
  p_postamble_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_oe) |-> (strb_oe && !strb_lvl));

endmodule

bind ddr2_rd_burst_gen ddr2rb_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .dq_oe    (dq_oe),
  .strb_lvl (strb_lvl),
  .strb_oe  (strb_oe)
);

// File: tb/sim_ddr2_rd_burst_gen.sv
module sim_ddr2_rd_burst_gen;

  localparam int COL_W  = 6;
  localparam int DATA_W = 8;
  localparam int NCOL   = 1 << COL_W;
  localparam int HORIZ  = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [COL_W-1:0]  col_addr = '0;
  logic [2:0]        cas_lat = 3'd3, add_lat = 3'd0;
  logic              bl8 = 1'b0;
  logic              wr_en = 1'b0;
  logic [COL_W-1:0]  wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] dq_rise, dq_fall;
  logic dq_oe, strb_lvl, strb_oe;

  always #4 clk = ~clk;

  ddr2_rd_burst_gen u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .col_addr(col_addr), .cas_lat(cas_lat), .add_lat(add_lat),
    .bl8(bl8), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
    .strb_lvl(strb_lvl), .strb_oe(strb_oe)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string ph = "R1 reset";

  logic [DATA_W-1:0] mdl [NCOL];
  bit                exp_dv [HORIZ];
  logic [DATA_W-1:0] exp_r [HORIZ];
  logic [DATA_W-1:0] exp_f [HORIZ];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL [%s] %s cyc=%0d actual=%0h expected=%0h",
               ph, req, cyc, act, exp);
    end
  endtask

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (cyc >= 1 && cyc < HORIZ - 1) begin
      bit dv, soe;
      dv  = exp_dv[cyc];
      soe = exp_dv[cyc] | exp_dv[cyc+1] | exp_dv[cyc-1];
      chk("R3 R4 dq_oe", 32'(dq_oe), 32'(dv));
      chk("R5 R8 R9 strb_oe", 32'(strb_oe), 32'(soe));
      chk("R6 strb_lvl", 32'(strb_lvl), 32'(dv));
      chk("R7 R10 dq_rise", 32'(dq_rise), dv ? 32'(exp_r[cyc]) : 32'd0);
      chk("R7 R10 dq_fall", 32'(dq_fall), dv ? 32'(exp_f[cyc]) : 32'd0);
    end
  end

  function automatic int clamp_cl(input int v);
    if (v < 3) return 3;
    if (v > 6) return 6;
    return v;
  endfunction

  function automatic int clamp_al(input int v);
    return (v > 4) ? 4 : v;
  endfunction

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = COL_W'(a); wr_data = DATA_W'(d);
    mdl[a] = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issue a READ at this negedge (captured at the next rising edge).
  task automatic rd(input int col, input int cl, input int al, input bit b8);
    int rl, bl, blk, first;
    rl    = clamp_cl(cl) + clamp_al(al);
    bl    = b8 ? 8 : 4;
    blk   = col & ~(bl - 1);
    first = cyc + 1 + rl;
    for (int k = 0; k < bl / 2; k++) begin
      exp_dv[first+k] = 1'b1;
      exp_r[first+k]  = mdl[blk | ((col + 2*k) % bl)];
      exp_f[first+k]  = mdl[blk | ((col + 2*k + 1) % bl)];
    end
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
    col_addr = COL_W'(col); cas_lat = 3'(cl); add_lat = 3'(al); bl8 = b8;
    @(negedge clk);
    cs_n = 1'b1; col_addr = '0; bl8 = 1'b0;
  endtask

  // Any non-READ pattern, with fields that would otherwise start a burst.
  task automatic other(input bit c, input bit r, input bit a, input bit w);
    cs_n = c; ras_n = r; cas_n = a; we_n = w;
    col_addr = 6'd9; cas_lat = 3'd3; add_lat = 3'd0; bl8 = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < HORIZ; i++) begin
      exp_dv[i] = 1'b0; exp_r[i] = '0; exp_f[i] = '0;
    end
    @(negedge clk);
    idle(3);
    rst = 1'b0;
    idle(2);

    ph = "R10 fill";
    for (int a = 0; a < NCOL; a++) wr(a, (a * 37 + 5) & 8'hff);
    idle(2);

    ph = "R3 R5 R8 al2 cl3 bl4";
    rd(0, 3, 2, 1'b0);
    idle(14);

    ph = "R4 R7 bl8 wrap col5 max latency";
    rd(5, 6, 4, 1'b1);
    idle(18);

    ph = "R7 bl4 wrap col14 min latency";
    rd(14, 3, 0, 1'b0);
    idle(10);

    ph = "R2 ignored patterns in flight";
    rd(20, 4, 1, 1'b1);
    other(1'b1, 1'b1, 1'b0, 1'b1);
    other(1'b0, 1'b0, 1'b0, 1'b1);
    other(1'b0, 1'b1, 1'b0, 1'b0);
    other(1'b0, 1'b1, 1'b1, 1'b1);
    other(1'b0, 1'b0, 1'b1, 1'b1);
    idle(16);

    ph = "R9 bl4 every 2 cycles";
    rd(33, 3, 2, 1'b0); idle(1);
    rd(40, 3, 2, 1'b0); idle(1);
    rd(47, 3, 2, 1'b0);
    idle(14);

    ph = "R9 bl8 every 4 cycles";
    rd(3, 5, 1, 1'b1); idle(3);
    rd(58, 5, 1, 1'b1);
    idle(18);

    ph = "R11 clamp cl7 al7";
    rd(11, 7, 7, 1'b0);
    idle(16);
    ph = "R11 clamp cl1";
    rd(26, 1, 0, 1'b1);
    idle(12);

    ph = "R10 rewrite then read";
    wr(44, 8'hc3); wr(45, 8'h3c); wr(46, 8'h7e); wr(47, 8'he7);
    rd(46, 4, 0, 1'b0);
    idle(12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL [%s] R3 watchdog expired actual=%0d expected=done", ph, cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule